// File: doc/BRIEF.md
# Start-up Reset Sequencer

This block drives the internal core reset of a chip. Two things must settle before that reset may release: the supply and the system oscillator. The block waits for both in turn, and each wait is timed by the clock that suits it. The supply wait is timed on a slow, always-running low-power clock. The oscillator wait counts cycles of the system oscillator itself. The block reports which phase it is in, so other logic can tell a cold start from a wake-up.

The external reset request and a supply-good flag from a brown-out monitor both count as reset sources. The sequence starts only when every source has let go. Two configuration selects set the two waits. They are captured once, at the start of the sequence. Setting the supply wait to zero skips the slow-clock phase, which suits a system that relies on the brown-out monitor. On a wake-from-sleep request, the block repeats only the oscillator wait. In that case the supply is assumed to be good already.

The phase code is 0 idle/held, 1 supply wait, 2 oscillator wait, 3 running.

Top module: `por_seq`

## Requirements
- R1: While `ext_rst` is 1 or `bod_ok` is 0, `phase` is 0 and `core_rst` is 1. This takes effect at once, without waiting for a clock edge.
- R2: At the first `osc_clk` rising edge after all reset sources release, `phase` leaves 0. It goes to 1 if `to_sel` is nonzero, or to 2 if `to_sel` is 0, which gives no supply wait.
- R3: Phase 1 lasts the selected number of `slow_clk` cycles, plus the synchroniser latency. The counts are: `to_sel` 1 gives 8, 2 gives 32, 3 gives 64. Measured in `osc_clk` cycles at the bench ratio of 4, the length lies between 4·N and 4·(N+3)+4.
- R4: The end of the slow-clock wait crosses into the oscillator domain through a two-flop synchroniser. Phase 1 is left only after the synchronised completion arrives.
- R5: Phase 2 lasts exactly the selected number of `osc_clk` cycles. The counts are: `su_sel` 0 gives 6, 1 gives 64, 2 gives 1024, 3 gives 32768.
- R6: `core_rst` is 1 in phases 0, 1 and 2. It drops to 0 in the same cycle that `phase` becomes 3.
- R7: A `wake_req` sampled in phase 3 moves the block straight to phase 2 and raises `core_rst` again. Phase 1 is skipped, and the oscillator count is the one latched at the last cold start.
- R8: A `wake_req` in any phase other than 3 has no effect on the sequence or its durations.
- R9: `to_sel` and `su_sel` are captured only in phase 0. Changes later in the sequence have no effect.
- R10: Raising any reset source in any phase returns the block to phase 0, and a full sequence follows the next release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | System oscillator clock |
| slow_clk | input | 1 | Slow low-power clock for the supply wait |
| ext_rst | input | 1 | External reset request, active high, asynchronous |
| bod_ok | input | 1 | Supply good from brown-out monitor, low acts as reset |
| wake_req | input | 1 | Wake-from-sleep request, `osc_clk` domain |
| to_sel | input | 2 | Supply wait select (0 = none, 1/2/3 = 8/32/64 slow cycles) |
| su_sel | input | 2 | Oscillator wait select (0/1/2/3 = 6/64/1024/32768 cycles) |
| core_rst | output | 1 | Internal reset, active high |
| phase | output | 2 | Current phase: 0 held, 1 supply wait, 2 oscillator wait, 3 running |

## Verification
The bound checker watches several properties on every oscillator cycle:
- the legal phase steps;
- the agreement between `core_rst` and phase 3;
- that phase 1 never ends before the synchronised completion arrives;
- that the start-up counter stays below its limit;
- that the latched selects are frozen outside phase 0;
- that a running block leaves phase 3 only on a wake request.

The actual lengths of both waits can only be shown by the bench's runs. So can the ignoring of select changes mid-sequence, the asynchronous return to phase 0 on a new reset, and the reuse of the latched count on wake-up. These runs are timed end to end at the ports with random and corner select codes.

// File: rtl/por_seq.sv
module por_seq #(
  parameter int TO_CYC1 = 8,
  parameter int TO_CYC2 = 32,
  parameter int TO_CYC3 = 64,
  parameter int SU_CYC0 = 6,
  parameter int SU_CYC1 = 64,
  parameter int SU_CYC2 = 1024,
  parameter int SU_CYC3 = 32768
) (
  input  logic       osc_clk,
  input  logic       slow_clk,
  input  logic       ext_rst,
  input  logic       bod_ok,
  input  logic       wake_req,
  input  logic [1:0] to_sel,
  input  logic [1:0] su_sel,
  output logic       core_rst,
  output logic [1:0] phase
);
  localparam int TOW = $clog2(TO_CYC3 + 1);
  localparam int SUW = $clog2(SU_CYC3 + 1);

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_WAIT = 2'd1, ST_OSC = 2'd2, ST_RUN = 2'd3} st_t;

  logic src_rst;
  assign src_rst = ext_rst | ~bod_ok;

  st_t st, st_n;
  logic [1:0] to_q, su_q;
  logic [SUW-1:0] su_cnt, su_lim;
  logic rst_q, go_q, done_m, done_s;
  logic go_m, go_s, done_q;
  logic [TOW-1:0] to_cnt, to_lim;

  assign su_lim = (su_q == 2'd0) ? SUW'(SU_CYC0) :
                  (su_q == 2'd1) ? SUW'(SU_CYC1) :
                  (su_q == 2'd2) ? SUW'(SU_CYC2) : SUW'(SU_CYC3);
  assign to_lim = (to_q == 2'd1) ? TOW'(TO_CYC1) :
                  (to_q == 2'd2) ? TOW'(TO_CYC2) : TOW'(TO_CYC3);

  always_comb begin
    st_n = st;
    case (st)
      ST_IDLE: st_n = (to_sel == 2'd0) ? ST_OSC : ST_WAIT;
      ST_WAIT: if (done_s) st_n = ST_OSC;
      ST_OSC:  if (su_cnt == su_lim - SUW'(1)) st_n = ST_RUN;
      default: if (wake_req) st_n = ST_OSC;
    endcase
  end

  always_ff @(posedge osc_clk or posedge src_rst) begin
    if (src_rst) begin
      st     <= ST_IDLE;
      to_q   <= 2'd0;
      su_q   <= 2'd0;
      su_cnt <= '0;
      rst_q  <= 1'b1;
      go_q   <= 1'b0;
      done_m <= 1'b0;
      done_s <= 1'b0;
    end else begin
      st <= st_n;
      if (st == ST_IDLE) begin
        to_q <= to_sel;
        su_q <= su_sel;
      end
      su_cnt <= (st == ST_OSC && st_n == ST_OSC) ? su_cnt + SUW'(1) : '0;
      rst_q  <= (st_n != ST_RUN);
      go_q   <= (st_n == ST_WAIT);
      done_m <= done_q;
      done_s <= done_m;
    end
  end

  always_ff @(posedge slow_clk or posedge src_rst) begin
    if (src_rst) begin
      go_m   <= 1'b0;
      go_s   <= 1'b0;
      done_q <= 1'b0;
      to_cnt <= '0;
    end else begin
      go_m <= go_q;
      go_s <= go_m;
      if (!go_s) begin
        to_cnt <= '0;
        done_q <= 1'b0;
      end else if (!done_q) begin
        if (to_cnt == to_lim - TOW'(1)) done_q <= 1'b1;
        to_cnt <= to_cnt + TOW'(1);
      end
    end
  end

  assign core_rst = rst_q;
  assign phase    = st;
endmodule

// File: rtl/por_seq_chk.sv
module por_seq_chk #(
  parameter int SUW = 16
) (
  input logic           osc_clk,
  input logic           src_rst,
  input logic           wake_req,
  input logic           done_s,
  input logic [1:0]     to_q,
  input logic [1:0]     su_q,
  input logic [SUW-1:0] su_cnt,
  input logic [SUW-1:0] su_lim,
  input logic           core_rst,
  input logic [1:0]     phase
);
  AST_RST_TRACKS_RUN: assert property (@(posedge osc_clk) disable iff (src_rst)
    core_rst == (phase != 2'd3)); // R6
  AST_IDLE_LEAVES: assert property (@(posedge osc_clk) disable iff (src_rst)
    phase == 2'd0 |=> (phase == 2'd1 || phase == 2'd2)); // R2
  AST_WAIT_STEP: assert property (@(posedge osc_clk) disable iff (src_rst)
    phase == 2'd1 |=> (phase == 2'd1 || phase == 2'd2)); // R3
  AST_WAIT_SYNC_GATE: assert property (@(posedge osc_clk) disable iff (src_rst)
    (phase == 2'd1 && !done_s) |=> phase == 2'd1); // R4
  AST_OSC_CNT_BOUND: assert property (@(posedge osc_clk) disable iff (src_rst)
    phase == 2'd2 |-> su_cnt < su_lim); // R5
  AST_OSC_STEP: assert property (@(posedge osc_clk) disable iff (src_rst)
    phase == 2'd2 |=> (phase == 2'd2 || phase == 2'd3)); // R5
  AST_WAKE_SKIPS_WAIT: assert property (@(posedge osc_clk) disable iff (src_rst)
    phase == 2'd3 |=> (phase == 2'd3 || phase == 2'd2)); // R7
  AST_RUN_HOLDS: assert property (@(posedge osc_clk) disable iff (src_rst)
    (phase == 2'd3 && !wake_req) |=> phase == 2'd3); // R8
  AST_CFG_FROZEN: assert property (@(posedge osc_clk) disable iff (src_rst)
    phase != 2'd0 |=> ($stable(to_q) && $stable(su_q))); // R9
endmodule

bind por_seq por_seq_chk #(.SUW(SUW)) u_chk (
  .osc_clk(osc_clk), .src_rst(src_rst), .wake_req(wake_req), .done_s(done_s),
  .to_q(to_q), .su_q(su_q), .su_cnt(su_cnt), .su_lim(su_lim),
  .core_rst(core_rst), .phase(phase)
);

// File: tb/sim_por_seq.sv
module sim_por_seq;
  logic osc_clk = 1'b0, slow_clk = 1'b0;
  logic ext_rst, bod_ok, wake_req;
  logic [1:0] to_sel, su_sel;
  logic core_rst;
  logic [1:0] phase;
  int nchk = 0, nfail = 0, cyc = 0;
  bit finished = 0;

  por_seq u0 (.osc_clk(osc_clk), .slow_clk(slow_clk), .ext_rst(ext_rst), .bod_ok(bod_ok),
              .wake_req(wake_req), .to_sel(to_sel), .su_sel(su_sel),
              .core_rst(core_rst), .phase(phase));

  always #4 osc_clk = ~osc_clk;
  initial begin #5; forever #16 slow_clk = ~slow_clk; end

  function automatic int su_exp(int c);
    return (c == 0) ? 6 : (c == 1) ? 64 : (c == 2) ? 1024 : 32768;
  endfunction
  function automatic int to_exp(int c);
    return (c == 0) ? 0 : (c == 1) ? 8 : (c == 2) ? 32 : 64;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge osc_clk) begin
    cyc++;
    if (cyc > 190000 && !finished) begin
      nfail++;
      $display("FAIL R5 watchdog expired actual=%0d expected=%0d", cyc, 190000);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  // counts samples per phase until RUN; start sample is the current one
  task automatic measure(bit wake_mid, output int n_to, output int n_su, output bit bad);
    n_to = 0; n_su = 0; bad = 0;
    for (int it = 0; it < 40000 && phase != 2'd3; it++) begin
      if (phase == 2'd1) n_to++;
      else if (phase == 2'd2) n_su++;
      else bad = 1;
      if (core_rst !== 1'b1) bad = 1;
      wake_req = (wake_mid && phase == 2'd2 && n_su == 2);
      @(negedge osc_clk);
    end
    wake_req = 0;
  endtask

  task automatic run_seq(int tc, int sc, bit scramble, bit wake_mid);
    int n_to, n_su; bit bad; int lo, hi;
    to_sel = 2'(tc); su_sel = 2'(sc);
    @(negedge osc_clk);
    ext_rst = 0; bod_ok = 1;
    @(negedge osc_clk);
    check(phase == ((tc == 0) ? 2'd2 : 2'd1), "R2", "phase after release", phase, (tc == 0) ? 2 : 1);
    if (scramble) begin to_sel = 2'($urandom); su_sel = 2'($urandom); end
    measure(wake_mid, n_to, n_su, bad);
    lo = to_exp(tc) * 4; hi = (tc == 0) ? 0 : (to_exp(tc) + 3) * 4 + 4;
    check(n_to >= lo && n_to <= hi, "R3", "supply wait length", n_to, lo);
    check(n_su == su_exp(sc), scramble ? "R9" : "R5", "osc wait length", n_su, su_exp(sc));
    if (wake_mid) check(n_su == su_exp(sc), "R8", "osc wait with early wake", n_su, su_exp(sc));
    check(!bad && phase == 2'd3 && core_rst == 1'b0, "R6", "release at run", {bad, core_rst}, 0);
  endtask

  task automatic wake_test(int sc);
    int n_to, n_su; bit bad;
    to_sel = 2'($urandom); su_sel = 2'($urandom);
    repeat (3) @(negedge osc_clk);
    check(phase == 2'd3, "R8", "run held without wake", phase, 3);
    wake_req = 1;
    @(negedge osc_clk);
    wake_req = 0;
    check(phase == 2'd2 && core_rst == 1'b1, "R7", "wake enters osc wait", phase, 2);
    measure(0, n_to, n_su, bad);
    check(n_to == 0 && !bad, "R7", "wake skips supply wait", n_to, 0);
    check(n_su == su_exp(sc), "R7", "wake uses latched count", n_su, su_exp(sc));
  endtask

  task automatic rst_hit(bit use_bod);
    if (use_bod) bod_ok = 0; else ext_rst = 1;
    #1;
    check(phase == 2'd0 && core_rst == 1'b1, use_bod ? "R1" : "R10", "async return to held", phase, 0);
    repeat (4) @(negedge osc_clk);
    check(phase == 2'd0 && core_rst == 1'b1, "R1", "held while source active", phase, 0);
  endtask

  task automatic abort_run(int tc, int sc, int k);
    to_sel = 2'(tc); su_sel = 2'(sc);
    @(negedge osc_clk);
    ext_rst = 0; bod_ok = 1;
    repeat (k) @(negedge osc_clk);
    rst_hit($urandom % 2);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    ext_rst = 1; bod_ok = 1; wake_req = 0; to_sel = 0; su_sel = 0;
    repeat (5) @(negedge osc_clk);
    check(phase == 2'd0 && core_rst == 1'b1, "R1", "reset state", phase, 0);

    run_seq(0, 0, 0, 0);
    wake_test(0);
    rst_hit(1);
    run_seq(1, 1, 1, 1);
    rst_hit(0);
    run_seq(3, 3, 1, 0);
    rst_hit(0);
    run_seq(2, 2, 0, 0);
    wake_test(2);
    rst_hit(0);

    for (int i = 0; i < 16; i++) begin
      int tc, sc;
      tc = $urandom % 4; sc = $urandom % 3;
      run_seq(tc, sc, 1, $urandom % 2);
      if ($urandom % 2) wake_test(sc);
      rst_hit($urandom % 2);
      abort_run($urandom % 4, $urandom % 3, 1 + $urandom % 300);
      ext_rst = 1;
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule